// File: doc/BRIEF.md
# Link BIST Error Status Tracker

This block sits at the receive end of a multi-lane serial link under built-in self test. The lane comparators, which are outside this block, report a per-lane error vector. A frame-valid strobe marks the cycles that close a received test frame. A start-delimiter flag marks the cycles that carry a frame start. The tracker folds these inputs into one control/status word. That word holds a saturating count of errored frames, the index of the lane that failed first, and a two-bit progress/result code.

Software launches a test by raising the start bit of the word, which also drives the transmit side into pattern mode. After that, software polls the word. The status, lane and count fields are sticky, and writing ones to them clears them. Two more control bits are held here. One is a loopback-map bit passed on to the far end. The other enables a rotating per-lane inversion mask, which feeds the transmit and receive pattern registers.

Top module: `lbist_err_tracker`

## Requirements
- R1: A write that takes the start bit (bit 0) from 0 to 1 launches a test. On the next cycle the status field (bits 5:4) reads 01, the lane field (bits 11:8) reads 0, the count field (bits 25:16) reads 0, and `tx_active_o` is 1.
- R2: While the status is 01, a cycle with `sdelim_i` high moves the status to 00.
- R3: While the status is 01, errored frames are ignored. Count, lane and status stay as they are.
- R4: An errored frame is a cycle with `frame_vld_i` high and at least one `lane_err_i` bit set. While the status is 00 and the test runs, such a frame sets the status to 10, loads the lane field and adds one to the count.
- R5: When several lane error bits are set in the capturing frame, the lane field holds the highest set bit index.
- R6: While the status is 10, lane and status are frozen. Each further errored frame adds exactly one to the count, and error bits without `frame_vld_i` add nothing.
- R7: The count saturates at 1023 and never wraps.
- R8: Writing 1 to the count, lane or status bits clears that field to 0 and leaves the other fields unchanged.
- R9: The status never reads 11.
- R10: With the start bit at 0, errored frames and delimiters change no field.
- R11: With the rotate-enable bit (bit 2) at 1, `inv_mask_o` rotates left by one lane each cycle. With it at 0, the mask holds.
- R12: After reset the word reads 0, `tx_active_o` and `lb_map_o` are 0, and `inv_mask_o` is 1. The loopback-map bit (bit 1) drives `lb_map_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read value |
| sdelim_i | input | 1 | Start delimiter seen this cycle |
| frame_vld_i | input | 1 | Frame check result valid this cycle |
| lane_err_i | input | NUM_LANES | Per-lane error flags from the comparators |
| tx_active_o | output | 1 | Transmit side sends test patterns |
| lb_map_o | output | 1 | Loopback lane mapping select |
| inv_mask_o | output | NUM_LANES | Rotating per-lane inversion mask |

## Verification
Every field update is registered once, so a write, a delimiter or an errored frame shows up in `csr_rdata_o` one clock edge after it is sampled. The bench drives inputs on the falling edge and reads back 1 ns after the next rising edge. Rotation follows the same one-edge rule, but it is governed by the enable bit as it stood before that edge. The rotation check therefore records the mask one cycle after the enabling write and expects the rotated value one cycle later. The saturation check holds an errored frame for more than 1023 cycles before it reads the count.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_WAIT = 2'b01,
    ST_FAIL = 2'b10
  } st_e;

  localparam int CSR_W      = 32;
  localparam int LANE_W     = 4;
  localparam int CNT_W      = 10;
  localparam int B_START    = 0;
  localparam int B_LBMAP    = 1;
  localparam int B_ROT      = 2;
  localparam int B_ST_LO    = 4;
  localparam int B_LANE_LO  = 8;
  localparam int B_CNT_LO   = 16;
endpackage

// File: rtl/lbist_lane_enc.sv
module lbist_lane_enc #(
  parameter int NUM_LANES = 10,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_LANES-1:0] err_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  // ascending scan: the last hit wins, giving the highest lane
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (err_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |err_i;
endmodule

// File: rtl/lbist_err_cnt.sv
module lbist_err_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (init_i || clr_i)         cnt_o <= '0;
    else if (inc_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lbist_status_ctl.sv
module lbist_status_ctl
  import lbist_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             clr_st_i,
  input  logic             clr_lane_i,
  input  logic             sdelim_i,
  input  logic             err_i,
  input  logic [IDX_W-1:0] err_lane_i,
  output st_e              st_o,
  output logic [IDX_W-1:0] lane_o,
  output logic             cnt_en_o
);
  st_e st_d;
  logic capture;

  assign capture  = (st_o == ST_OK) && err_i && !clr_st_i;
  assign cnt_en_o = err_i && (st_o != ST_WAIT);

  always_comb begin
    st_d = st_o;
    if (init_i) begin
      st_d = ST_WAIT;
    end else if (clr_st_i) begin
      st_d = ST_OK;
    end else begin
      unique case (st_o)
        ST_WAIT: if (sdelim_i) st_d = ST_OK;
        ST_OK:   if (err_i)    st_d = ST_FAIL;
        default: st_d = st_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o   <= ST_OK;
      lane_o <= '0;
    end else begin
      st_o <= st_d;
      if (init_i || clr_lane_i) lane_o <= '0;
      else if (capture)         lane_o <= err_lane_i;
    end
  end
endmodule

// File: rtl/lbist_inv_rot.sv
module lbist_inv_rot #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] mask_o
);
  localparam logic [W-1:0] Seed = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= Seed;
    else if (en_i) mask_o <= {mask_o[W-2:0], mask_o[W-1]};
  end
endmodule

// File: rtl/lbist_err_tracker.sv
module lbist_err_tracker
  import lbist_pkg::*;
#(
  parameter int NUM_LANES = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 csr_we_i,
  input  logic [31:0]          csr_wdata_i,
  output logic [31:0]          csr_rdata_o,
  input  logic                 sdelim_i,
  input  logic                 frame_vld_i,
  input  logic [NUM_LANES-1:0] lane_err_i,
  output logic                 tx_active_o,
  output logic                 lb_map_o,
  output logic [NUM_LANES-1:0] inv_mask_o
);
  logic start_q, lbmap_q, rot_q;
  logic launch, clr_st, clr_lane, clr_cnt;
  logic err_any, frame_err;
  logic [LANE_W-1:0] err_idx, lane_q;
  logic [CNT_W-1:0]  cnt_q;
  logic cnt_en;
  st_e  st_q;
  logic unused_wdata;

  assign unused_wdata = ^{csr_wdata_i[31:26], csr_wdata_i[15:12], csr_wdata_i[7:6], csr_wdata_i[3]};

  assign launch   = csr_we_i && csr_wdata_i[B_START] && !start_q;
  assign clr_st   = csr_we_i && |csr_wdata_i[B_ST_LO +: 2];
  assign clr_lane = csr_we_i && |csr_wdata_i[B_LANE_LO +: LANE_W];
  assign clr_cnt  = csr_we_i && |csr_wdata_i[B_CNT_LO +: CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      lbmap_q <= 1'b0;
      rot_q   <= 1'b0;
    end else if (csr_we_i) begin
      start_q <= csr_wdata_i[B_START];
      lbmap_q <= csr_wdata_i[B_LBMAP];
      rot_q   <= csr_wdata_i[B_ROT];
    end
  end

  lbist_lane_enc #(.NUM_LANES(NUM_LANES), .IDX_W(LANE_W)) i_enc (
    .err_i (lane_err_i),
    .any_o (err_any),
    .idx_o (err_idx)
  );

  assign frame_err = start_q && frame_vld_i && err_any;

  lbist_status_ctl #(.IDX_W(LANE_W)) i_st (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (launch),
    .clr_st_i   (clr_st),
    .clr_lane_i (clr_lane),
    .sdelim_i   (sdelim_i && start_q),
    .err_i      (frame_err),
    .err_lane_i (err_idx),
    .st_o       (st_q),
    .lane_o     (lane_q),
    .cnt_en_o   (cnt_en)
  );

  lbist_err_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (launch),
    .clr_i  (clr_cnt),
    .inc_i  (cnt_en),
    .cnt_o  (cnt_q)
  );

  lbist_inv_rot #(.W(NUM_LANES)) i_rot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rot_q),
    .mask_o (inv_mask_o)
  );

  always_comb begin
    csr_rdata_o = '0;
    csr_rdata_o[B_START]               = start_q;
    csr_rdata_o[B_LBMAP]               = lbmap_q;
    csr_rdata_o[B_ROT]                 = rot_q;
    csr_rdata_o[B_ST_LO +: 2]          = st_q;
    csr_rdata_o[B_LANE_LO +: LANE_W]   = lane_q;
    csr_rdata_o[B_CNT_LO +: CNT_W]     = cnt_q;
  end

  assign tx_active_o = start_q;
  assign lb_map_o    = lbmap_q;
endmodule

// File: rtl/lbist_err_tracker_chk.sv
module lbist_err_tracker_chk #(
  parameter int NUM_LANES = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 csr_we_i,
  input logic [31:0]          csr_rdata_o,
  input logic [NUM_LANES-1:0] inv_mask_o
);
  logic [1:0] st;
  logic [3:0] lane;
  logic [9:0] cnt;
  logic run, rot;
  assign st   = csr_rdata_o[5:4];
  assign lane = csr_rdata_o[11:8];
  assign cnt  = csr_rdata_o[25:16];
  assign run  = csr_rdata_o[0];
  assign rot  = csr_rdata_o[2];

  p_st_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st != 2'b11);

  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && cnt == 10'h3ff) |=> cnt == 10'h3ff);

  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> (cnt == $past(cnt) || cnt == $past(cnt) + 10'd1));

  p_lane_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && st == 2'b10) |=> ($stable(lane) && st == 2'b10));

  p_wait_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && st == 2'b01) |=> ($stable(cnt) && $stable(lane)));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i && !run) |=> $stable(csr_rdata_o));

  p_rot_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rot |=> $stable(inv_mask_o));

  p_rot_on_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot |=> inv_mask_o == {$past(inv_mask_o[NUM_LANES-2:0]), $past(inv_mask_o[NUM_LANES-1])});

  logic unused_chk;
  assign unused_chk = ^{csr_rdata_o[31:26], csr_rdata_o[15:12], csr_rdata_o[7:6], csr_rdata_o[3], csr_rdata_o[1]};
endmodule

bind lbist_err_tracker lbist_err_tracker_chk #(.NUM_LANES(NUM_LANES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_we_i    (csr_we_i),
  .csr_rdata_o (csr_rdata_o),
  .inv_mask_o  (inv_mask_o)
);

// File: tb/test_lbist_err_tracker.sv
`timescale 1ns/1ps
module test_lbist_err_tracker;
  localparam int NL = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          csr_we_i = 1'b0;
  logic [31:0]   csr_wdata_i = '0;
  logic [31:0]   csr_rdata_o;
  logic          sdelim_i = 1'b0;
  logic          frame_vld_i = 1'b0;
  logic [NL-1:0] lane_err_i = '0;
  logic          tx_active_o, lb_map_o;
  logic [NL-1:0] inv_mask_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  lbist_err_tracker #(.NUM_LANES(NL)) i_lbist_err_tracker (
    .clk_i, .rst_ni, .csr_we_i, .csr_wdata_i, .csr_rdata_o,
    .sdelim_i, .frame_vld_i, .lane_err_i, .tx_active_o, .lb_map_o, .inv_mask_o
  );

  // {sdelim, vld, err[9:0], exp_st[1:0], exp_lane[3:0], exp_cnt[9:0]}
  localparam logic [27:0] VEC [8] = '{
    {1'b0, 1'b1, 10'h004, 2'b01, 4'd0, 10'd0},  // R3 error before delimiter
    {1'b1, 1'b0, 10'h000, 2'b00, 4'd0, 10'd0},  // R2
    {1'b0, 1'b1, 10'h000, 2'b00, 4'd0, 10'd0},  // R4 clean frame
    {1'b0, 1'b0, 10'h008, 2'b00, 4'd0, 10'd0},  // R6 no strobe
    {1'b0, 1'b1, 10'h012, 2'b10, 4'd4, 10'd1},  // R4 R5 lanes 1,4
    {1'b0, 1'b1, 10'h200, 2'b10, 4'd4, 10'd2},  // R6
    {1'b1, 1'b1, 10'h001, 2'b10, 4'd4, 10'd3},  // R6
    {1'b0, 1'b1, 10'h000, 2'b10, 4'd4, 10'd3}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    csr_we_i = 1'b1; csr_wdata_i = d;
    @(posedge clk_i); #1;
    csr_we_i = 1'b0; csr_wdata_i = '0;
  endtask

  task automatic step(input logic sd, input logic vld, input logic [NL-1:0] e);
    @(negedge clk_i);
    sdelim_i = sd; frame_vld_i = vld; lane_err_i = e;
    @(posedge clk_i); #1;
    sdelim_i = 1'b0; frame_vld_i = 1'b0; lane_err_i = '0;
  endtask

  function automatic logic [NL-1:0] rotl(input logic [NL-1:0] m);
    return {m[NL-2:0], m[NL-1]};
  endfunction

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NL-1:0] m0;
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 word", csr_rdata_o, 32'h0);
    chk("R12 tx", {31'b0, tx_active_o}, 32'h0);
    chk("R12 mask", {22'b0, inv_mask_o}, 32'h1);

    // R10 idle: errors and delimiter ignored
    step(1'b1, 1'b1, 10'h3ff);
    chk("R10 idle", csr_rdata_o, 32'h0);

    wr(32'h1);
    chk("R1 launch", csr_rdata_o, 32'h0000_0011);
    chk("R1 tx", {31'b0, tx_active_o}, 32'h1);

    foreach (VEC[i]) begin
      step(VEC[i][27], VEC[i][26], VEC[i][25:16]);
      chk($sformatf("vec%0d st", i), {30'b0, csr_rdata_o[5:4]}, {30'b0, VEC[i][15:14]});
      chk($sformatf("vec%0d lane", i), {28'b0, csr_rdata_o[11:8]}, {28'b0, VEC[i][13:10]});
      chk($sformatf("vec%0d cnt", i), {22'b0, csr_rdata_o[25:16]}, {22'b0, VEC[i][9:0]});
    end

    // R8 clear count only
    wr(32'h03ff_0001);
    chk("R8 cnt clr", csr_rdata_o, 32'h0000_0421);
    wr(32'h0000_0f31);
    chk("R8 lane/st clr", csr_rdata_o, 32'h0000_0001);
    step(1'b0, 1'b1, 10'h008);
    chk("R4 recapture", csr_rdata_o, 32'h0001_0321);

    // R1 relaunch reinitializes
    wr(32'h0);
    wr(32'h1);
    chk("R1 relaunch", csr_rdata_o, 32'h0000_0011);

    // R7 saturation
    step(1'b1, 1'b0, '0);
    for (int k = 0; k < 1030; k++) step(1'b0, 1'b1, 10'h001);
    chk("R7 sat", csr_rdata_o, 32'h03ff_0021);
    chk("R9 st legal", {30'b0, csr_rdata_o[5:4]}, 32'h2);

    // R12 loopback bit, R11 rotation
    wr(32'h3);
    chk("R12 lbmap", {31'b0, lb_map_o}, 32'h1);
    m0 = inv_mask_o;
    step(1'b0, 1'b0, '0);
    chk("R11 hold", {22'b0, inv_mask_o}, {22'b0, m0});
    wr(32'h5);
    m0 = inv_mask_o;
    step(1'b0, 1'b0, '0);
    chk("R11 rot1", {22'b0, inv_mask_o}, {22'b0, rotl(m0)});
    step(1'b0, 1'b0, '0);
    chk("R11 rot2", {22'b0, inv_mask_o}, {22'b0, rotl(rotl(m0))});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule